// File: doc/BRIEF.md
# Oversampled Buffer Latency Meter

This block reports the latency through an elastic buffer at a resolution finer than one cycle of the buffer's main clock. The buffer's write and read pointers come from the main-clock domain. They are carried into a separate measurement-clock domain as Gray codes through two-flop synchronizers. In the measurement domain the block takes the pointer difference, which is the buffer fill in 32-bit words. One word of fill stands for one main-clock period of delay.

The measurement clock is chosen so that N of its periods span exactly M main-clock periods, with M and N whole numbers. When M/N is close to 1, the sampling phase walks slowly across the main-clock period. Over a window of N measurement cycles the block adds up the N fill samples. It then publishes the sum and raises a valid flag. Software divides the published sum by N to get the delay in main-clock cycles; for example, a sum of 4221 with N=127 means about 33.24 cycles.

When the measurement clock is simply the main clock, the block still works and gives whole-cycle results. The same meter is instantiated once per traffic direction. Each direction has its own period, result and valid flag.

Top module: `lat_meter`

## Requirements
- R1: After reset every direction reports a delay of 0 and a valid flag of 0.
- R2: A published delay is the sum of N occupancy samples taken on N consecutive measurement-clock edges, so a constant fill of F words gives exactly N*F.
- R3: Occupancy is write pointer minus read pointer modulo 2^PTR_W, so pointers that have wrapped give the correct fill.
- R4: While N is nonzero and unchanged, a new result is published every N measurement-clock cycles. After N is written, the first result appears on the N-th edge after the edge that takes in the new N.
- R5: Publishing a result sets the valid flag. A read strobe with no coinciding result clears it on the next edge.
- R6: When a read strobe and a new result fall on the same edge, the valid flag stays set.
- R7: N=0 disables measurement. No result is published, the valid flag is never set, and the published delay holds its last value.
- R8: A change of N restarts the window and discards the partial sum, so the first result after the change holds only samples taken under the new N.
- R9: With the measurement clock driven by the main clock (M/N = 1), results are still exactly N times the whole-word fill.
- R10: Each direction has its own pointers, period, read strobe, delay and valid flag. Activity in one direction does not affect the result of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_main_i | input | 1 | Buffer main clock; the pointers are sampled on it |
| clk_meas_i | input | 1 | Measurement clock; every other input and output is in this domain |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| wr_ptr_i | input | NUM_DIR x PTR_W | Binary write pointer per direction (main domain) |
| rd_ptr_i | input | NUM_DIR x PTR_W | Binary read pointer per direction (main domain) |
| period_i | input | NUM_DIR x PER_W | Window length N per direction; 0 disables measurement |
| rd_strobe_i | input | NUM_DIR | One-cycle pulse marking a read of the result; clears valid |
| delay_o | output | NUM_DIR x ACC_W | Last published sum of occupancy samples |
| valid_o | output | NUM_DIR | A result has been published since the last read strobe |

## Verification
The bench goes after the read/publish collision. A design that lets the clear win would drop a fresh result, and the valid flag would fall. It rewrites N partway through a long window and times the first result. A meter that kept the old partial sum or the old count would report late or report too large a value. Pointers that straddle the wrap point catch a fill computed without modulo arithmetic, which shows up as a huge sum. N=0 must leave the flag low and the published value frozen, and a second direction must keep its own result while the first is busy.

// File: rtl/lat_meter_pkg.sv
package lat_meter_pkg;
  parameter int unsigned PTR_W_DEF = 8;
  parameter int unsigned PER_W_DEF = 8;
  parameter int unsigned ACC_W_DEF = 24;
  parameter int unsigned NUM_DIR_DEF = 2;
endpackage

// File: rtl/lat_gray_sync.sv
module lat_gray_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_src_i,
  input  logic         clk_dst_i,
  input  logic         rst_ni,
  input  logic [W-1:0] bin_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] gray_src_q, sync1_q, sync2_q;
  logic [W-1:0] bin_dst;

  always_ff @(posedge clk_src_i or negedge rst_ni) begin
    if (!rst_ni) gray_src_q <= '0;
    else         gray_src_q <= bin_i ^ (bin_i >> 1);
  end

  always_ff @(posedge clk_dst_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= gray_src_q;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    bin_dst[W-1] = sync2_q[W-1];
    for (int i = int'(W) - 2; i >= 0; i--) begin
      bin_dst[i] = bin_dst[i+1] ^ sync2_q[i];
    end
  end

  assign bin_o = bin_dst;
endmodule

// File: rtl/lat_meter_core.sv
module lat_meter_core #(
  parameter int unsigned PTR_W = 8,
  parameter int unsigned PER_W = 8,
  parameter int unsigned ACC_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PTR_W-1:0] wr_bin_i,
  input  logic [PTR_W-1:0] rd_bin_i,
  input  logic [PER_W-1:0] period_i,
  input  logic             rd_strobe_i,
  output logic [ACC_W-1:0] delay_o,
  output logic             valid_o
);
  logic [PTR_W-1:0] occ;
  logic [PER_W-1:0] period_q, cnt_q;
  logic [ACC_W-1:0] acc_q, acc_sum, delay_q;
  logic             valid_q, restart, enable, done;

  assign occ     = wr_bin_i - rd_bin_i;  // modulo fill
  assign restart = period_i != period_q;
  assign enable  = period_q != '0;
  assign acc_sum = acc_q + ACC_W'(occ);
  assign done    = enable && !restart && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= '0;
      cnt_q    <= '0;
      acc_q    <= '0;
      delay_q  <= '0;
    end else begin
      period_q <= period_i;
      if (restart) begin
        acc_q <= '0;
        cnt_q <= (period_i == '0) ? '0 : period_i - 1'b1;
      end else if (enable) begin
        if (cnt_q == '0) begin
          delay_q <= acc_sum;
          acc_q   <= '0;
          cnt_q   <= period_q - 1'b1;
        end else begin
          acc_q <= acc_sum;
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  // publish wins over read clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          valid_q <= 1'b0;
    else if (done)        valid_q <= 1'b1;
    else if (rd_strobe_i) valid_q <= 1'b0;
  end

  assign delay_o = delay_q;
  assign valid_o = valid_q;

  p_valid_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> valid_o);
  p_valid_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_strobe_i && !done) |=> !valid_o);
  p_collide_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_strobe_i && done) |=> valid_o);
  p_disabled_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_i == '0 && period_q == '0) |=> ($stable(delay_o) && !$rose(valid_o)));
  p_cnt_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable && !restart) |-> (cnt_q < period_q));
  p_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart && period_i != '0) |=> (cnt_q == $past(period_i) - 1'b1 && acc_q == '0));
endmodule

// File: rtl/lat_meter.sv
module lat_meter
  import lat_meter_pkg::*;
#(
  parameter int unsigned NUM_DIR = NUM_DIR_DEF,
  parameter int unsigned PTR_W   = PTR_W_DEF,
  parameter int unsigned PER_W   = PER_W_DEF,
  parameter int unsigned ACC_W   = ACC_W_DEF
) (
  input  logic                           clk_main_i,
  input  logic                           clk_meas_i,
  input  logic                           rst_ni,
  input  logic [NUM_DIR-1:0][PTR_W-1:0] wr_ptr_i,
  input  logic [NUM_DIR-1:0][PTR_W-1:0] rd_ptr_i,
  input  logic [NUM_DIR-1:0][PER_W-1:0] period_i,
  input  logic [NUM_DIR-1:0]            rd_strobe_i,
  output logic [NUM_DIR-1:0][ACC_W-1:0] delay_o,
  output logic [NUM_DIR-1:0]            valid_o
);
  for (genvar d = 0; d < int'(NUM_DIR); d++) begin : g_dir
    logic [PTR_W-1:0] wr_meas, rd_meas;

    lat_gray_sync #(.W(PTR_W)) u_wr_sync (
      .clk_src_i(clk_main_i), .clk_dst_i(clk_meas_i), .rst_ni(rst_ni),
      .bin_i(wr_ptr_i[d]), .bin_o(wr_meas)
    );
    lat_gray_sync #(.W(PTR_W)) u_rd_sync (
      .clk_src_i(clk_main_i), .clk_dst_i(clk_meas_i), .rst_ni(rst_ni),
      .bin_i(rd_ptr_i[d]), .bin_o(rd_meas)
    );
    lat_meter_core #(.PTR_W(PTR_W), .PER_W(PER_W), .ACC_W(ACC_W)) u_core (
      .clk_i(clk_meas_i), .rst_ni(rst_ni),
      .wr_bin_i(wr_meas), .rd_bin_i(rd_meas),
      .period_i(period_i[d]), .rd_strobe_i(rd_strobe_i[d]),
      .delay_o(delay_o[d]), .valid_o(valid_o[d])
    );
  end
endmodule

// File: tb/tb_lat_meter.sv
`timescale 1ns/1ps
module tb_lat_meter;
  logic clk = 1'b0, clk_beat = 1'b0, use_main = 1'b0, rst_n = 1'b0;
  logic clk_meas;
  logic [1:0][7:0]  wr_ptr, rd_ptr, period;
  logic [1:0]       rd_strobe;
  logic [1:0][23:0] delay;
  logic [1:0]       valid;
  int checks = 0, failures = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;              // 250 MHz main clock
  always #2.032 clk_beat = ~clk_beat; // beat clock, slightly slower
  assign clk_meas = use_main ? clk : clk_beat;

  lat_meter dut (
    .clk_main_i(clk), .clk_meas_i(clk_meas), .rst_ni(rst_n),
    .wr_ptr_i(wr_ptr), .rd_ptr_i(rd_ptr), .period_i(period),
    .rd_strobe_i(rd_strobe), .delay_o(delay), .valid_o(valid)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe(int d);
    rd_strobe[d] = 1'b1;
    @(negedge clk_meas);
    rd_strobe[d] = 1'b0;
  endtask

  task automatic wait_valid(int d);
    for (int k = 0; k < 3000 && !valid[d]; k++) @(negedge clk_meas);
  endtask

  task automatic set_ptr(int d, int wr, int rd);
    wr_ptr[d] = 8'(wr);
    rd_ptr[d] = 8'(rd);
    repeat (8) @(negedge clk_meas);
  endtask

  task automatic measure(int d, output int res);
    for (int r = 0; r < 3; r++) begin
      strobe(d);
      wait_valid(d);
    end
    res = int'(delay[d]);
  endtask

  task automatic t_reset();
    check("R1 delay0", int'(delay[0]), 0);
    check("R1 valid0", int'(valid[0]), 0);
    check("R1 valid1", int'(valid[1]), 0);
  endtask

  task automatic t_const_fill();
    int res;
    period[0] = 8'd8;
    set_ptr(0, 15, 10);
    measure(0, res);
    check("R2 fill5 N8", res, 40);
    set_ptr(0, 33, 33);
    measure(0, res);
    check("R2 fill0", res, 0);
    period[0] = 8'd127;
    set_ptr(0, 40, 7);
    measure(0, res);
    check("R2 fill33 N127", res, 127 * 33);
  endtask

  task automatic t_wrap();
    int res;
    period[0] = 8'd8;
    set_ptr(0, 2, 254);
    measure(0, res);
    check("R3 wrap fill4", res, 32);
  endtask

  task automatic t_read_clear();
    wait_valid(0);
    check("R5 valid set", int'(valid[0]), 1);
    strobe(0);
    check("R5 cleared", int'(valid[0]), 0);
  endtask

  task automatic t_collide();
    // window N=4: next publish falls N edges after the last
    period[0] = 8'd4;
    repeat (8) @(negedge clk_meas);
    strobe(0);
    wait_valid(0);
    repeat (3) @(negedge clk_meas);
    strobe(0);
    check("R6 collide keeps valid", int'(valid[0]), 1);
  endtask

  task automatic t_restart();
    int n = 0;
    set_ptr(0, 6, 0);
    period[0] = 8'd200;
    repeat (3) @(negedge clk_meas);
    strobe(0);
    repeat (50) @(negedge clk_meas);
    check("R4 no result mid window", int'(valid[0]), 0);
    period[0] = 8'd10;
    while (!valid[0] && n < 500) begin
      @(negedge clk_meas);
      n++;
    end
    check("R4 first result timing", n, 11);
    check("R8 partial discarded", int'(delay[0]), 60);
  endtask

  task automatic t_disable();
    int prev;
    period[0] = 8'd8;
    set_ptr(0, 3, 0);
    wait_valid(0);
    @(negedge clk_meas);
    prev = int'(delay[0]);
    period[0] = 8'd0;
    strobe(0);
    set_ptr(0, 9, 0);
    repeat (300) @(negedge clk_meas);
    check("R7 valid stays low", int'(valid[0]), 0);
    check("R7 delay held", int'(delay[0]), prev);
  endtask

  task automatic t_same_clock();
    int res;
    use_main = 1'b1;
    period[0] = 8'd16;
    set_ptr(0, 7, 0);
    measure(0, res);
    check("R9 same clock N16 fill7", res, 112);
    use_main = 1'b0;
    repeat (8) @(negedge clk_meas);
  endtask

  task automatic t_dirs();
    int r0, r1;
    period[0] = 8'd8;
    period[1] = 8'd16;
    set_ptr(0, 2, 0);
    set_ptr(1, 109, 100);
    measure(1, r1);
    measure(0, r0);
    check("R10 dir1", r1, 144);
    check("R10 dir0", r0, 16);
    measure(1, r1);
    check("R10 dir1 unchanged", r1, 144);
  endtask

  initial begin
    wr_ptr = '0; rd_ptr = '0; period = '0; rd_strobe = '0;
    repeat (4) @(negedge clk_meas);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk_meas);
    t_const_fill();
    t_wrap();
    t_read_clear();
    t_collide();
    t_restart();
    t_disable();
    t_same_clock();
    t_dirs();
    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule